// File: doc/BRIEF.md
# Twiddle Rotation Angle Generator

This block supplies the rotation angles for the four twiddle rotations of a split-radix 2/8 FFT butterfly without storing any twiddle values. It keeps a phase accumulator that grows by one full turn per butterfly index, so it holds 2π·n. A right shift by log2(N) turns that into the base angle θ = 2π·n/N. A shift-and-add stage then forms θ, 3θ, 5θ and 7θ for the same index. All angles are 16-bit binary angles: 2^16 counts make one full turn, so wrap-around needs no extra logic.

A controller pulses `start_i` at the beginning of a pass and `advance_i` once per butterfly. The transform size is taken from `log2n_i` only on a start pulse. One clock after each update the four angles appear on registered outputs, with a one-cycle `ang_valid_o` pulse. The index runs from 0 to N/8 − 1 and then returns to 0.

Top module: `twg_angle_gen`

## Requirements
- R1: After reset all four angle outputs are 0, `ang_valid_o` is 0, and the size setting is log2(N) = 7, so an advance with no start first gives θ = 512.
- R2: A `start_i` pulse clears the index to 0. The outputs that follow are all 0.
- R3: Each `advance_i` pulse increments the index n. `ang1_o` then equals (n·2^16/N) mod 2^16.
- R4: `ang3_o` equals (3·n·2^16/N) mod 2^16 for the same index.
- R5: `ang5_o` equals (5·n·2^16/N) mod 2^16 for the same index.
- R6: `ang7_o` equals (7·n·2^16/N) mod 2^16 for the same index.
- R7: `ang_valid_o` is 1 in exactly the cycle after the output register loads. The output register loads one clock after an edge where start or advance was sampled. In every other cycle `ang_valid_o` is 0 and the angle outputs hold their values. Back-to-back advances give one new angle set per cycle.
- R8: On a start pulse, `log2n_i` values from 7 to 13 become the new size. Any other value leaves the previous size in place.
- R9: An advance taken when the index is N/8 − 1 returns the index to 0.
- R10: When `start_i` and `advance_i` are high in the same cycle, the start takes effect and the advance is ignored, so the index is 0.
- R11: `log2n_i` has no effect unless `start_i` is high. Changing it during advances or idle cycles does not change the angles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a pass: clear the index and capture the size |
| advance_i | input | 1 | Step to the next butterfly index |
| log2n_i | input | 4 | Transform size exponent, sampled on start |
| ang1_o | output | 16 | Base angle θ as a binary angle |
| ang3_o | output | 16 | 3θ |
| ang5_o | output | 16 | 5θ |
| ang7_o | output | 16 | 7θ |
| ang_valid_o | output | 1 | One-cycle pulse when a new angle set is loaded |

## Verification
The hardest case to reach from the ports is the index wrap at the largest size. There the index must climb through 1023 advances at log2(N) = 13 before the return to 0 can be seen. A directed burst of back-to-back advances gets there, checking every angle set on the way. Random stimulus covers the rest: it mixes start pulses carrying legal and illegal sizes, simultaneous start and advance, and `log2n_i` noise on non-start cycles. Those patterns exercise the size-capture and priority rules against a model that tracks only the index and the size.

// File: rtl/twg_pkg.sv
package twg_pkg;

    localparam int ANG_W      = 16;
    localparam int LOG2N_MIN  = 7;
    localparam int LOG2N_MAX  = 13;
    localparam int RADIX_LOG2 = 3;
    localparam int LANES      = 4;
    localparam int LOG2N_W    = $clog2(LOG2N_MAX + 1);
    localparam int IDX_W      = LOG2N_MAX - RADIX_LOG2;
    localparam int ACC_W      = ANG_W + IDX_W;

    typedef logic [ANG_W-1:0]   angle_t;
    typedef logic [LOG2N_W-1:0] log2n_t;
    typedef logic [ACC_W-1:0]   acc_t;
    typedef logic [IDX_W-1:0]   idx_t;

    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_CLEAR = 2'd1,
        CMD_STEP  = 2'd2
    } cmd_e;

    typedef struct packed {
        angle_t a7;
        angle_t a5;
        angle_t a3;
        angle_t a1;
    } angle_set_t;

    function automatic logic size_legal(log2n_t v);
        return (v >= log2n_t'(LOG2N_MIN)) && (v <= log2n_t'(LOG2N_MAX));
    endfunction

    // Highest butterfly index for the size: N/8 - 1
    function automatic idx_t last_index(log2n_t v);
        idx_t one;
        one = idx_t'(1);
        return (one << (v - log2n_t'(RADIX_LOG2))) - one;
    endfunction

    // Lane g produces the multiple 2g+1 of the base angle
    function automatic int unsigned lane_shift(int g);
        return (g == 3) ? 3 : unsigned'(g);
    endfunction

    function automatic logic lane_subtract(int g);
        return g == 3;
    endfunction

    function automatic angle_t odd_multiple(angle_t base, int unsigned sh, logic sub);
        angle_t scaled;
        scaled = base << sh;
        return sub ? (scaled - base) : (scaled + base);
    endfunction

endpackage

// File: rtl/twg_cmd_decode.sv
module twg_cmd_decode
    import twg_pkg::*;
(
    input  logic start_i,
    input  logic advance_i,
    output cmd_e cmd_o
);
    always_comb begin
        if (start_i)
            cmd_o = CMD_CLEAR;
        else if (advance_i)
            cmd_o = CMD_STEP;
        else
            cmd_o = CMD_HOLD;
    end
endmodule

// File: rtl/twg_size_reg.sv
module twg_size_reg
    import twg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  cmd_e   cmd_i,
    input  log2n_t log2n_i,
    output log2n_t size_o
);
    log2n_t size_q;

    always_ff @(posedge clk) begin
        if (rst)
            size_q <= log2n_t'(LOG2N_MIN);
        else if (cmd_i == CMD_CLEAR && size_legal(log2n_i))
            size_q <= log2n_i;
    end

    assign size_o = size_q;
endmodule

// File: rtl/twg_phase_acc.sv
module twg_phase_acc
    import twg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  cmd_e   cmd_i,
    input  log2n_t size_i,
    output acc_t   acc_o,
    output logic   upd_o
);
    localparam acc_t TURN = acc_t'(1) << ANG_W;

    acc_t acc_q;
    logic upd_q;
    idx_t idx;
    logic at_last;

    assign idx     = acc_q[ACC_W-1 -: IDX_W];
    assign at_last = (idx == last_index(size_i));

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            upd_q <= 1'b0;
        end else begin
            upd_q <= (cmd_i != CMD_HOLD);
            case (cmd_i)
                CMD_CLEAR: acc_q <= '0;
                CMD_STEP:  acc_q <= at_last ? acc_t'(0) : acc_q + TURN;
                default:   acc_q <= acc_q;
            endcase
        end
    end

    assign acc_o = acc_q;
    assign upd_o = upd_q;
endmodule

// File: rtl/twg_angle_scale.sv
module twg_angle_scale
    import twg_pkg::*;
(
    input  acc_t   acc_i,
    input  log2n_t size_i,
    output angle_t base_o
);
    acc_t shifted;

    assign shifted = acc_i >> size_i;
    assign base_o  = shifted[ANG_W-1:0];
endmodule

// File: rtl/twg_odd_mult.sv
module twg_odd_mult
    import twg_pkg::*;
#(
    parameter int NLANE = LANES
) (
    input  angle_t base_i,
    output angle_t lane_o [NLANE]
);
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        if (g == 0) begin : g_pass
            assign lane_o[g] = base_i;
        end else begin : g_sa
            assign lane_o[g] = odd_multiple(base_i, lane_shift(g), lane_subtract(g));
        end
    end
endmodule

// File: rtl/twg_angle_gen.sv
module twg_angle_gen
    import twg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        advance_i,
    input  logic [3:0]  log2n_i,
    output logic [15:0] ang1_o,
    output logic [15:0] ang3_o,
    output logic [15:0] ang5_o,
    output logic [15:0] ang7_o,
    output logic        ang_valid_o
);
    cmd_e       cmd;
    log2n_t     size;
    acc_t       acc;
    logic       upd;
    angle_t     base;
    angle_t     lanes [LANES];
    angle_set_t set_d;
    angle_set_t set_q;
    logic       valid_q;

    twg_cmd_decode u_dec (
        .start_i   (start_i),
        .advance_i (advance_i),
        .cmd_o     (cmd)
    );

    twg_size_reg u_size (
        .clk     (clk),
        .rst     (rst),
        .cmd_i   (cmd),
        .log2n_i (log2n_t'(log2n_i)),
        .size_o  (size)
    );

    twg_phase_acc u_acc (
        .clk    (clk),
        .rst    (rst),
        .cmd_i  (cmd),
        .size_i (size),
        .acc_o  (acc),
        .upd_o  (upd)
    );

    twg_angle_scale u_scale (
        .acc_i  (acc),
        .size_i (size),
        .base_o (base)
    );

    twg_odd_mult #(.NLANE(LANES)) u_mult (
        .base_i (base),
        .lane_o (lanes)
    );

    always_comb begin
        set_d.a1 = lanes[0];
        set_d.a3 = lanes[1];
        set_d.a5 = lanes[2];
        set_d.a7 = lanes[3];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            set_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= upd;
            if (upd)
                set_q <= set_d;
        end
    end

    assign ang1_o      = set_q.a1;
    assign ang3_o      = set_q.a3;
    assign ang5_o      = set_q.a5;
    assign ang7_o      = set_q.a7;
    assign ang_valid_o = valid_q;
endmodule

// File: rtl/twg_angle_gen_chk.sv
module twg_angle_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic        start_i,
    input logic        advance_i,
    input logic [15:0] ang1_o,
    input logic [15:0] ang3_o,
    input logic [15:0] ang5_o,
    input logic [15:0] ang7_o,
    input logic        ang_valid_o
);
    p_valid_after_cmd_r7: assert property (@(posedge clk) disable iff (rst)
        (start_i || advance_i) |=> ##1 ang_valid_o);

    p_quiet_when_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !advance_i) |=> ##1 (!ang_valid_o && $stable(ang1_o) && $stable(ang3_o)
                                         && $stable(ang5_o) && $stable(ang7_o)));

    p_start_zero_r2: assert property (@(posedge clk) disable iff (rst)
        start_i |=> ##1 (ang1_o == 16'd0 && ang3_o == 16'd0 && ang5_o == 16'd0 && ang7_o == 16'd0));

    p_triple_r4: assert property (@(posedge clk) disable iff (rst)
        ang_valid_o |-> (ang3_o == 16'(ang1_o * 16'd3)));

    p_quintuple_r5: assert property (@(posedge clk) disable iff (rst)
        ang_valid_o |-> (ang5_o == 16'(ang1_o * 16'd5)));

    p_septuple_r6: assert property (@(posedge clk) disable iff (rst)
        ang_valid_o |-> (ang7_o == 16'(ang1_o * 16'd7)));
endmodule

bind twg_angle_gen twg_angle_gen_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .advance_i   (advance_i),
    .ang1_o      (ang1_o),
    .ang3_o      (ang3_o),
    .ang5_o      (ang5_o),
    .ang7_o      (ang7_o),
    .ang_valid_o (ang_valid_o)
);

// File: tb/twg_angle_gen_test.sv
`timescale 1ns/1ps
module twg_angle_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        advance_i = 1'b0;
    logic [3:0]  log2n_i = 4'd0;
    logic [15:0] ang1_o, ang3_o, ang5_o, ang7_o;
    logic        ang_valid_o;

    int checks = 0;
    int errors = 0;
    int m_size = 7;
    int m_idx  = 0;

    always #2.5 clk = ~clk;

    twg_angle_gen uut (
        .clk(clk), .rst(rst), .start_i(start_i), .advance_i(advance_i),
        .log2n_i(log2n_i), .ang1_o(ang1_o), .ang3_o(ang3_o),
        .ang5_o(ang5_o), .ang7_o(ang7_o), .ang_valid_o(ang_valid_o)
    );

    function automatic logic [15:0] exp_angle(int k, int n, int sz);
        longint v;
        v = (longint'(k) * longint'(n) * 65536) / (longint'(1) << sz);
        return 16'(v % 65536);
    endfunction

    function automatic int pass_len(int sz);
        return 1 << (sz - 3);
    endfunction

    task automatic check_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_angles(string req, int n, int sz);
        check_eq(req, "ang1", int'(ang1_o), int'(exp_angle(1, n, sz)));
        check_eq(req, "ang3", int'(ang3_o), int'(exp_angle(3, n, sz)));
        check_eq(req, "ang5", int'(ang5_o), int'(exp_angle(5, n, sz)));
        check_eq(req, "ang7", int'(ang7_o), int'(exp_angle(7, n, sz)));
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // One command cycle, then observe the load cycle and the quiet cycle after it
    task automatic op(logic st, logic adv, int l, string req);
        bit cmd;
        cmd = st || adv;
        @(negedge clk);
        start_i = st; advance_i = adv; log2n_i = 4'(l);
        @(negedge clk);
        start_i = 1'b0; advance_i = 1'b0; log2n_i = 4'($urandom % 16);
        if (st) begin
            if (l >= 7 && l <= 13) m_size = l;
            m_idx = 0;
        end else if (adv) begin
            m_idx = (m_idx + 1) % pass_len(m_size);
        end
        @(negedge clk);
        check_eq(req, "valid_load", int'(ang_valid_o), cmd ? 1 : 0);
        check_angles(req, m_idx, m_size);
        @(negedge clk);
        check_eq("R7", "valid_quiet", int'(ang_valid_o), 0);
        check_angles("R7", m_idx, m_size);
    endtask

    // Back-to-back advances: sample at negedge m shows the index after edge m-2
    task automatic burst(int len, string req);
        int n0;
        int cnt;
        n0  = m_idx;
        cnt = pass_len(m_size);
        for (int m = 0; m <= len + 1; m++) begin
            @(negedge clk);
            if (m >= 2) begin
                check_eq(req, "burst_valid", int'(ang_valid_o), 1);
                check_angles(req, (n0 + m - 1) % cnt, m_size);
            end
            advance_i = (m < len);
            log2n_i   = 4'($urandom % 16);
        end
        m_idx = (n0 + len) % cnt;
        @(negedge clk);
        check_eq("R7", "burst_end_valid", int'(ang_valid_o), 0);
        check_angles("R7", m_idx, m_size);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check_eq("R1", "valid_reset", int'(ang_valid_o), 0);
        check_angles("R1", 0, 7);
        // R1: default size 7 without any start
        op(1'b0, 1'b1, 3, "R1");
        check_eq("R1", "ang1_default", int'(ang1_o), 512);
        // R2: start clears
        op(1'b1, 1'b0, 9, "R2");
        // R3..R6: several steps at size 9
        op(1'b0, 1'b1, 0, "R3");
        op(1'b0, 1'b1, 0, "R4");
        op(1'b0, 1'b1, 0, "R5");
        op(1'b0, 1'b1, 0, "R6");
        // R8: illegal sizes keep previous
        op(1'b1, 1'b0, 15, "R8");
        op(1'b0, 1'b1, 0, "R8");
        op(1'b1, 1'b0, 6, "R8");
        op(1'b0, 1'b1, 0, "R8");
        op(1'b1, 1'b0, 14, "R8");
        op(1'b0, 1'b1, 2, "R8");
        // R10: start beats advance
        op(1'b0, 1'b1, 0, "R3");
        op(1'b1, 1'b1, 11, "R10");
        check_eq("R10", "ang1_zero", int'(ang1_o), 0);
        // R11: size poke without start, then advance
        op(1'b0, 1'b0, 7, "R11");
        op(1'b0, 1'b1, 8, "R11");
        // R9: wrap at smallest size
        op(1'b1, 1'b0, 7, "R9");
        burst(16, "R9");
        check_eq("R9", "wrap_idx0", int'(ang1_o), 0);
        op(1'b0, 1'b1, 13, "R9");
        // R9: wrap at largest size via long burst
        op(1'b1, 1'b0, 13, "R9");
        burst(1024, "R9");
        check_eq("R9", "wrap13_idx0", int'(ang1_o), 0);
        // R3/R7: burst at mid size
        op(1'b1, 1'b0, 10, "R3");
        burst(40, "R7");
        // Random mix
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom % 16;
            if (r < 2)
                op(1'b1, 1'b0, int'($urandom % 16), "R8");
            else if (r == 2)
                op(1'b1, 1'b1, int'($urandom % 16), "R10");
            else if (r == 3)
                op(1'b0, 1'b0, int'($urandom % 16), "R11");
            else
                op(1'b0, 1'b1, int'($urandom % 16), "R3");
        end
        finish_run();
    end

endmodule